// File: doc/BRIEF.md
# Serial Memory Write-Protect Controller

This block decides, for every decoded byte request of a byte-addressed serial memory, whether the request is acknowledged and whether it changes anything. It owns a protection register that sits at the all-ones address. The register holds two volatile enable latches, two block-lock bits and a protect-enable bit. The bus front end presents requests on a simple decoded interface: a frame-start pulse, one pulse per data byte with its address and data, a stop pulse, and a read strobe. The controller answers each request one cycle later.

The two block-lock bits and the protect-enable bit are nonvolatile. They are kept in a register that only the power-on reset clears, and they change only through a nonvolatile cycle that begins at the stop. Array writes also start a nonvolatile cycle at the stop, unless the target is locked. While a cycle runs, a busy output stays high for a parameterized number of clocks and every request is refused. When the external protect pin and the protect-enable bit are both high, the nonvolatile register is frozen. This lets a board turn a locked region into a read-only area that can still be programmed in circuit.

Top module: `wp_ctrl`

## Requirements
- R1: `por_n` low clears every bit of the protection register. `rst_n` low clears only the two volatile latches and the busy timer and keeps the block-lock and protect-enable bits.
- R2: Every request gets a response one cycle later: `rsp_valid` high with `rsp_ack`. A read of address 16'hFFFF returns the image bit7 protect-enable, bits 6..5 zero, bit4 block-lock high, bit3 block-lock low, bit2 register-write latch, bit1 write latch, bit0 zero, and pulses `cnt_clr`. A read of any other address returns 8'h00 without `cnt_clr`. Bits 0, 5 and 6 of `rd_data` are always zero.
- R3: While the register-write latch is clear, writing a byte with bit1 set to 16'hFFFF sets the write latch, and a byte with bit1 clear clears it. The change shows at once and starts no busy period.
- R4: A register write with any of bits 0, 5 or 6 set is not acknowledged and changes nothing.
- R5: Only the first data byte after a frame start at 16'hFFFF is acknowledged. Later bytes in that frame are refused and have no effect.
- R6: While the write latch is clear, writes to any address other than 16'hFFFF are refused, and the following stop starts no busy period.
- R7: Writing 8'h06 to 16'hFFFF sets the register-write latch only when the write latch is set. With that latch set, a byte with bit2 clear and bit1 set stages bit7 and bits 4..3, and the stop commits them with a busy period.
- R8: Every nonvolatile cycle, whether it comes from a register write or an array write, clears the register-write latch.
- R9: While `wp_pin` and the protect-enable bit are both high (`hw_lock`), register writes to the nonvolatile bits are acknowledged but discarded and start no busy period. The volatile latches can still be written.
- R10: Block-lock value 0 protects nothing, 1 protects addresses with both top bits set, 2 protects addresses with the top bit set, and 3 protects every address. A write to a protected address is acknowledged but ignored. A write to an unprotected address with the write latch set starts a busy period at the stop.
- R11: `nv_go` pulses and `busy` stays high for exactly NV_CYCLES cycles after a committing stop. Requests made while busy are refused and change nothing.
- R12: While the register-write latch is set, writing 8'h00 to 16'hFFFF does not clear the write latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the volatile state |
| por_n | input | 1 | Active-low power-on reset, also clears the nonvolatile bits |
| wp_pin | input | 1 | External write-protect pin |
| wr_start | input | 1 | Start of a write frame |
| wr_byte | input | 1 | One data byte of a write, with addr and data |
| stop | input | 1 | End of frame |
| rd_req | input | 1 | Random byte read of addr |
| addr | input | AW | Byte address |
| data | input | 8 | Write data byte |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_ack | output | 1 | Request acknowledged |
| rd_data | output | 8 | Read data |
| cnt_clr | output | 1 | Address counter must be zeroed |
| busy | output | 1 | Nonvolatile cycle in progress |
| nv_go | output | 1 | One-cycle pulse when a nonvolatile cycle begins |
| hw_lock | output | 1 | Hardware protection active |

## Verification
The hardest state to reach is a hardware lock with the register-write latch set. Getting there needs the latch sequence, a committed nonvolatile cycle that sets the protect-enable bit while the pin is low, then the pin raised and the latch sequence run again. Only in that state can the bench show that a staged clear of the protect-enable bit is acknowledged and then dropped, and that the latch survives because no cycle ran. The bench drives that sequence in order and then lowers the pin to show that the same write now commits. A behavioural model that runs on every clock compares the responses, busy, nv_go and cnt_clr.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef struct packed {
    logic       pen;
    logic [1:0] blk;
  } nv_bits_t;

  typedef enum logic [2:0] {
    REGOP_NONE,
    REGOP_WEL_SET,
    REGOP_WEL_CLR,
    REGOP_RWEL_SET,
    REGOP_NV_STAGE
  } reg_op_e;

  localparam logic [7:0] RSVD_MASK = 8'h61;

  function automatic logic [7:0] reg_image(nv_bits_t nv, logic rwel, logic wel);
    return {nv.pen, 2'b00, nv.blk, rwel, wel, 1'b0};
  endfunction

  function automatic logic region_locked(logic [1:0] top2, logic [1:0] blk);
    case (blk)
      2'd0:    return 1'b0;
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic reg_op_e classify(logic [7:0] d, logic wel, logic rwel);
    if (d[2] && d[1]) begin
      if (wel && !d[7] && d[4:3] == 2'b00) return REGOP_RWEL_SET;
      return REGOP_NONE;
    end
    if (d[2]) return REGOP_NONE;
    if (rwel) return d[1] ? REGOP_NV_STAGE : REGOP_NONE;
    return d[1] ? REGOP_WEL_SET : REGOP_WEL_CLR;
  endfunction

endpackage

// File: rtl/wpc_decode.sv
module wpc_decode
  import wpc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          wr_byte,
  input  logic          rd_req,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  input  logic          first,
  input  logic          busy,
  input  logic          wel,
  input  logic          rwel,
  input  nv_bits_t      nv,
  input  logic          hw_lock,
  output logic          ack,
  output logic          wel_set,
  output logic          wel_clr,
  output logic          rwel_set,
  output logic          nv_stage,
  output logic          arr_accept,
  output logic          cnt_zero,
  output logic [7:0]    rd_val
);
  logic    at_reg;
  reg_op_e op;

  assign at_reg = &addr;
  assign op     = classify(data, wel, rwel);

  always_comb begin
    ack        = 1'b0;
    wel_set    = 1'b0;
    wel_clr    = 1'b0;
    rwel_set   = 1'b0;
    nv_stage   = 1'b0;
    arr_accept = 1'b0;
    cnt_zero   = 1'b0;
    rd_val     = 8'h00;
    if (!busy) begin
      if (rd_req) begin
        ack = 1'b1;
        if (at_reg) begin
          rd_val   = reg_image(nv, rwel, wel);
          cnt_zero = 1'b1;
        end
      end else if (wr_byte) begin
        if (at_reg) begin
          if (first && (data & RSVD_MASK) == 8'h00) begin
            ack      = 1'b1;
            wel_set  = (op == REGOP_WEL_SET);
            wel_clr  = (op == REGOP_WEL_CLR);
            rwel_set = (op == REGOP_RWEL_SET);
            nv_stage = (op == REGOP_NV_STAGE) && !hw_lock;
          end
        end else if (wel) begin
          ack        = 1'b1;
          arr_accept = !region_locked(addr[AW-1:AW-2], nv.blk);
        end
      end
    end
  end

endmodule

// File: rtl/wpc_latches.sv
module wpc_latches
  import wpc_pkg::*;
(
  input  logic     clk,
  input  logic     vol_rst_n,
  input  logic     por_n,
  input  logic     wel_set,
  input  logic     wel_clr,
  input  logic     rwel_set,
  input  logic     nv_stage,
  input  nv_bits_t stage_bits,
  input  logic     arr_accept,
  input  logic     stop,
  input  logic     busy,
  input  logic     hw_lock,
  output logic     wel,
  output logic     rwel,
  output nv_bits_t nv,
  output logic     commit,
  output logic     nv_go
);
  logic     pend_reg, pend_arr;
  nv_bits_t staged;
  logic     stop_ok, commit_reg;

  assign stop_ok    = stop && !busy;
  assign commit_reg = stop_ok && pend_reg && !hw_lock;
  assign commit     = commit_reg || (stop_ok && pend_arr);

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n) begin
      wel      <= 1'b0;
      rwel     <= 1'b0;
      pend_reg <= 1'b0;
      pend_arr <= 1'b0;
      staged   <= '0;
      nv_go    <= 1'b0;
    end else begin
      nv_go <= commit;
      if (wel_set)  wel  <= 1'b1;
      if (wel_clr)  wel  <= 1'b0;
      if (rwel_set) rwel <= 1'b1;
      if (nv_stage) begin
        pend_reg <= 1'b1;
        staged   <= stage_bits;
      end
      if (arr_accept) pend_arr <= 1'b1;
      if (stop_ok) begin
        pend_reg <= 1'b0;
        pend_arr <= 1'b0;
      end
      if (commit) rwel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          nv <= '0;
    else if (commit_reg) nv <= staged;
  end

  AST_RWEL_DROPS: assert property (@(posedge clk) disable iff (!vol_rst_n)
    nv_go |-> !rwel); // R8
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!vol_rst_n || !por_n)
    hw_lock |=> $stable(nv)); // R9
  AST_WEL_KEPT: assert property (@(posedge clk) disable iff (!vol_rst_n)
    (rwel && wel) |=> wel); // R12

endmodule

// File: rtl/wpc_nv_timer.sv
module wpc_nv_timer #(
  parameter int NV_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(NV_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [CW:0]   run_len;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (go)          cnt <= CW'(NV_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R11
  AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy); // R11
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == (CW+1)'(NV_CYCLES)); // R11

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wpc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NV_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          wp_pin,
  input  logic          wr_start,
  input  logic          wr_byte,
  input  logic          stop,
  input  logic          rd_req,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  output logic          rsp_valid,
  output logic          rsp_ack,
  output logic [7:0]    rd_data,
  output logic          cnt_clr,
  output logic          busy,
  output logic          nv_go,
  output logic          hw_lock
);
  logic     vol_rst_n;
  logic     first;
  logic     wel, rwel, commit;
  nv_bits_t nv, stage_bits;
  logic     d_ack, d_wel_set, d_wel_clr, d_rwel_set, d_nv_stage, d_arr_accept, d_cnt_zero;
  logic [7:0] d_rd_val;

  assign vol_rst_n  = rst_n & por_n;
  assign hw_lock    = wp_pin & nv.pen;
  assign stage_bits = '{pen: data[7], blk: data[4:3]};

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n)    first <= 1'b0;
    else if (wr_start) first <= 1'b1;
    else if (wr_byte)  first <= 1'b0;
  end

  wpc_decode #(.AW(AW)) u_decode (
    .wr_byte    (wr_byte),
    .rd_req     (rd_req),
    .addr       (addr),
    .data       (data),
    .first      (first),
    .busy       (busy),
    .wel        (wel),
    .rwel       (rwel),
    .nv         (nv),
    .hw_lock    (hw_lock),
    .ack        (d_ack),
    .wel_set    (d_wel_set),
    .wel_clr    (d_wel_clr),
    .rwel_set   (d_rwel_set),
    .nv_stage   (d_nv_stage),
    .arr_accept (d_arr_accept),
    .cnt_zero   (d_cnt_zero),
    .rd_val     (d_rd_val)
  );

  wpc_latches u_latches (
    .clk        (clk),
    .vol_rst_n  (vol_rst_n),
    .por_n      (por_n),
    .wel_set    (d_wel_set),
    .wel_clr    (d_wel_clr),
    .rwel_set   (d_rwel_set),
    .nv_stage   (d_nv_stage),
    .stage_bits (stage_bits),
    .arr_accept (d_arr_accept),
    .stop       (stop),
    .busy       (busy),
    .hw_lock    (hw_lock),
    .wel        (wel),
    .rwel       (rwel),
    .nv         (nv),
    .commit     (commit),
    .nv_go      (nv_go)
  );

  wpc_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (vol_rst_n),
    .go    (commit),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      rd_data   <= 8'h00;
      cnt_clr   <= 1'b0;
    end else begin
      rsp_valid <= wr_byte | rd_req;
      rsp_ack   <= d_ack;
      cnt_clr   <= d_cnt_zero;
      if (rd_req) rd_data <= d_rd_val;
    end
  end

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!vol_rst_n)
    ((wr_byte || rd_req) && busy) |=> (rsp_valid && !rsp_ack)); // R11
  AST_NO_WEL_NO_ACK: assert property (@(posedge clk) disable iff (!vol_rst_n)
    (wr_byte && !(&addr) && !wel) |=> !rsp_ack); // R6
  AST_EXTRA_BYTE_NACK: assert property (@(posedge clk) disable iff (!vol_rst_n)
    (wr_byte && (&addr) && !first) |=> !rsp_ack); // R5
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!vol_rst_n)
    rsp_valid |-> (rd_data & RSVD_MASK) == 8'h00); // R2

endmodule

// File: tb/wp_ctrl_bench.sv
module wp_ctrl_bench;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0, wp_pin = 1'b0;
  logic wr_start = 1'b0, wr_byte = 1'b0, stop = 1'b0, rd_req = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  data = 8'h0;
  logic rsp_valid, rsp_ack, cnt_clr, busy, nv_go, hw_lock;
  logic [7:0] rd_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  wp_ctrl #(.AW(16), .NV_CYCLES(NV)) u_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wp_pin(wp_pin),
    .wr_start(wr_start), .wr_byte(wr_byte), .stop(stop), .rd_req(rd_req),
    .addr(addr), .data(data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rd_data(rd_data), .cnt_clr(cnt_clr), .busy(busy), .nv_go(nv_go),
    .hw_lock(hw_lock)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_wel, m_rwel, m_pen, m_blk, m_spen, m_sblk, m_pr, m_pa, m_first, m_cnt;
  int e_rv, e_ack, e_rd, e_clr, e_go;

  function automatic int protected_at(int a, int blk);
    if (blk == 0) return 0;
    if (blk == 1) return (a >= 'hC000) ? 1 : 0;
    if (blk == 2) return (a >= 'h8000) ? 1 : 0;
    return 1;
  endfunction

  function automatic int image();
    return m_pen * 128 + m_blk * 8 + m_rwel * 4 + m_wel * 2;
  endfunction

  always @(posedge clk) begin
    int lock, was_busy, go;
    if (!por_n) begin
      m_pen = 0; m_blk = 0;
    end
    if (!por_n || !rst_n) begin
      m_wel = 0; m_rwel = 0; m_pr = 0; m_pa = 0; m_first = 0; m_cnt = 0;
      m_spen = 0; m_sblk = 0;
      e_rv = 0; e_ack = 0; e_rd = 0; e_clr = 0; e_go = 0;
    end else begin
      lock = (wp_pin && m_pen == 1) ? 1 : 0;
      was_busy = (m_cnt > 0) ? 1 : 0;
      go = 0; e_rv = 0; e_clr = 0;
      if (wr_byte || rd_req) begin e_rv = 1; e_ack = 0; end
      if (!was_busy) begin
        if (rd_req) begin
          e_ack = 1;
          if (addr == 16'hFFFF) begin e_rd = image(); e_clr = 1; end
          else e_rd = 0;
        end else if (wr_byte) begin
          if (addr == 16'hFFFF) begin
            if (m_first == 1 && (data & 8'h61) == 0) begin
              e_ack = 1;
              if (data[2] && data[1]) begin
                if (m_wel == 1 && data[7] == 0 && data[4:3] == 0) m_rwel = 1;
              end else if (!data[2]) begin
                if (m_rwel == 1) begin
                  if (data[1] && lock == 0) begin m_pr = 1; m_spen = data[7]; m_sblk = data[4:3]; end
                end else m_wel = data[1];
              end
            end
          end else begin
            e_ack = m_wel;
            if (m_wel == 1 && protected_at(addr, m_blk) == 0) m_pa = 1;
          end
        end
        if (stop) begin
          if (m_pr == 1 && lock == 0) begin m_pen = m_spen; m_blk = m_sblk; go = 1; end
          if (m_pa == 1) go = 1;
          m_pr = 0; m_pa = 0;
          if (go == 1) m_rwel = 0;
        end
      end
      if (wr_start) m_first = 1;
      else if (wr_byte) m_first = 0;
      e_go = go;
      if (go == 1) m_cnt = NV;
      else if (was_busy == 1) m_cnt = m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && por_n && !done) begin
      check("R11", "busy", busy, (m_cnt > 0) ? 1 : 0);
      check("R11", "nv_go", nv_go, e_go);
      check("R2", "rsp_valid", rsp_valid, e_rv);
      check("R2", "cnt_clr", cnt_clr, e_clr);
      check("R9", "hw_lock", hw_lock, (wp_pin && m_pen == 1) ? 1 : 0);
      if (e_rv == 1) begin
        check(cur_tag, "rsp_ack", rsp_ack, e_ack);
        if (rd_req === 1'b0 && e_clr == 1) check(cur_tag, "rd_data", rd_data, e_rd);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic start();
    @(negedge clk); wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d, output logic ack);
    @(negedge clk); wr_byte = 1'b1; addr = a; data = d;
    @(negedge clk); wr_byte = 1'b0; ack = rsp_ack;
  endtask

  task automatic finish_frame(output int busy_len);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    busy_len = 0;
    while (busy) begin busy_len++; @(negedge clk); end
  endtask

  task automatic reg_wr(input string tag, input logic [7:0] d, input int exp_ack, input int exp_busy);
    logic a; int bl;
    cur_tag = tag;
    start();
    put(16'hFFFF, d, a);
    check(tag, "reg write ack", a, exp_ack);
    finish_frame(bl);
    check(tag, "busy length", bl, exp_busy);
  endtask

  task automatic arr_wr(input string tag, input logic [15:0] a_in, input int exp_ack, input int exp_busy);
    logic a; int bl;
    cur_tag = tag;
    start();
    put(a_in, 8'h5A, a);
    check(tag, "array write ack", a, exp_ack);
    finish_frame(bl);
    check(tag, "busy length", bl, exp_busy);
  endtask

  task automatic rd_reg(input string tag, input int exp);
    cur_tag = tag;
    @(negedge clk); rd_req = 1'b1; addr = 16'hFFFF;
    @(negedge clk); rd_req = 1'b0;
    check(tag, "register image", rd_data, exp);
    check(tag, "counter clear", cnt_clr, 1);
  endtask

  initial begin
    logic a; int bl;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after power-on", busy, 0);
    rd_reg("R1", 8'h00);
    // non-register read
    cur_tag = "R2";
    @(negedge clk); rd_req = 1'b1; addr = 16'h1234;
    @(negedge clk); rd_req = 1'b0;
    check("R2", "other read data", rd_data, 8'h00);
    check("R2", "other read no clear", cnt_clr, 0);
    arr_wr("R6", 16'h0100, 0, 0);
    reg_wr("R3", 8'h02, 1, 0);
    rd_reg("R3", 8'h02);
    reg_wr("R3", 8'h00, 1, 0);
    rd_reg("R3", 8'h00);
    reg_wr("R3", 8'h02, 1, 0);
    reg_wr("R4", 8'h03, 0, 0);
    reg_wr("R4", 8'h42, 0, 0);
    rd_reg("R4", 8'h02);
    // two bytes in one register frame
    cur_tag = "R5";
    start();
    put(16'hFFFF, 8'h02, a); check("R5", "first byte ack", a, 1);
    put(16'hFFFF, 8'h00, a); check("R5", "second byte nack", a, 0);
    finish_frame(bl);
    rd_reg("R5", 8'h02);
    // register-write latch and a nonvolatile commit
    reg_wr("R7", 8'h06, 1, 0);
    rd_reg("R7", 8'h06);
    reg_wr("R12", 8'h00, 1, 0);
    rd_reg("R12", 8'h06);
    reg_wr("R7", 8'h0A, 1, NV);
    rd_reg("R8", 8'h0A);
    // block lock 1: upper quarter
    arr_wr("R10", 16'hC000, 1, 0);
    reg_wr("R8", 8'h06, 1, 0);
    arr_wr("R10", 16'h8000, 1, NV);
    rd_reg("R8", 8'h0A);
    // block lock 2: upper half
    reg_wr("R7", 8'h06, 1, 0);
    reg_wr("R7", 8'h12, 1, NV);
    arr_wr("R10", 16'h8000, 1, 0);
    arr_wr("R10", 16'h7FFF, 1, NV);
    // rst_n alone keeps nonvolatile bits
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_reg("R1", 8'h10);
    arr_wr("R6", 16'h0010, 0, 0);
    reg_wr("R3", 8'h02, 1, 0);
    // block lock 3 plus protect enable, pin low
    reg_wr("R7", 8'h06, 1, 0);
    reg_wr("R7", 8'h9A, 1, NV);
    rd_reg("R7", 8'h9A);
    arr_wr("R10", 16'h0000, 1, 0);
    // hardware lock
    @(negedge clk); wp_pin = 1'b1;
    reg_wr("R9", 8'h06, 1, 0);
    rd_reg("R9", 8'h9E);
    reg_wr("R9", 8'h02, 1, 0);
    rd_reg("R9", 8'h9E);
    @(negedge clk); wp_pin = 1'b0;
    reg_wr("R9", 8'h02, 1, NV);
    rd_reg("R9", 8'h02);
    // requests during busy are refused
    arr_wr("R11", 16'h4000, 1, NV);
    cur_tag = "R11";
    start();
    put(16'h4001, 8'h11, a);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0; rd_req = 1'b1; addr = 16'hFFFF;
    @(negedge clk); rd_req = 1'b0;
    check("R11", "read while busy nack", rsp_ack, 0);
    check("R11", "no clear while busy", cnt_clr, 0);
    @(negedge clk); wr_byte = 1'b1; addr = 16'hFFFF; data = 8'h00;
    @(negedge clk); wr_byte = 1'b0;
    check("R11", "write while busy nack", rsp_ack, 0);
    while (busy) @(negedge clk);
    rd_reg("R11", 8'h02);
    // power-on reset clears everything
    reg_wr("R7", 8'h06, 1, 0);
    reg_wr("R7", 8'h8A, 1, NV);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd_reg("R1", 8'h00);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule